// File: doc/BRIEF.md
# Isochronous Endpoint Retire Controller

This block follows one isochronous endpoint of a USB device through successive (micro)frames and decides when the active transfer descriptor is finished. Software primes the endpoint. The exchange then opens at the start-of-frame marker of the following frame. From that point, a per-frame packet counter, loaded from the descriptor or from the endpoint, counts down with each data packet. The descriptor retires when the counter empties, or, on a receive endpoint, when a data packet with a PID other than MDATA arrives. A frame that ends with some of its packets but not all of them forces a retire with the transaction-error flag set.

Received data is never retried. A packet with a bad CRC is stored and counted like any other packet, and the transaction-error flag records the problem. A packet that is longer than the endpoint maximum, or longer than the descriptor still has room for, raises the buffer-error flag. The byte budget then saturates at zero. The error flags and the request for the next descriptor hold until the next prime, so that software can read them. A packet event that reaches the endpoint while it is not open is dropped and reported on a one-clock stray pulse.

Top module: `iso_retire_ctrl`

## Requirements
- R1: After synchronous reset, retire, txn_err, buf_err, next_req and stray_pkt are 0, bytes_left is 0, and the endpoint is idle.
- R2: A prime stores a target frame index equal to the last start-of-frame index seen plus one, modulo 2^FRM_W. The endpoint opens only on a start-of-frame whose index equals that target. A start-of-frame with any other index leaves the endpoint waiting.
- R3: Each time a frame opens, the packet counter loads the descriptor override when the override is nonzero. Otherwise it loads the endpoint multiplier. A value of 0 in both fields gives 1.
- R4: Each accepted packet decrements the counter. The packet that brings the counter to zero retires the descriptor: retire is high for exactly the one cycle after that packet's clock edge, next_req rises with it, and the endpoint goes idle.
- R5: On a receive endpoint (ep_is_tx=0), an accepted packet whose PID code is not MDATA retires the descriptor at once. The PID codes are DATA0=0, DATA1=1, DATA2=2 and MDATA=3.
- R6: If a start-of-frame arrives while the endpoint is open and the ending frame saw at least one packet, which means fewer than the loaded multiplier, the block sets txn_err, pulses retire and sets next_req.
- R7: An open endpoint that sees no packets stays open across any number of start-of-frames. It then never retires, and its counter reloads at each start-of-frame.
- R8: An accepted receive packet with pkt_crc_bad=1 sets txn_err. Its bytes are still deducted from bytes_left, and the packet does not retire the descriptor by itself.
- R9: An accepted receive packet whose byte count is greater than ep_max_pkt sets buf_err.
- R10: On a prime, bytes_left loads dtd_byte_total. Every accepted packet subtracts its byte count. If a receive packet is larger than bytes_left, buf_err is set and bytes_left becomes 0.
- R11: txn_err, buf_err and next_req hold their values until the next prime, and that prime clears all three.
- R12: A packet event that arrives while the endpoint is not open, or in the same cycle as a prime or a start-of-frame, is ignored. The block pulses stray_pkt for one cycle and leaves bytes_left and the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dtd_mult_ovr | input | 2 | Descriptor multiplier override, 0 = use endpoint value |
| dtd_byte_total | input | BYTE_W | Descriptor byte budget, loaded on prime |
| ep_mult | input | 2 | Endpoint packets-per-frame multiplier |
| ep_max_pkt | input | PKT_W | Endpoint maximum packet length |
| ep_is_tx | input | 1 | 1 = transmit endpoint, 0 = receive |
| prime | input | 1 | Prime strobe from software |
| sof | input | 1 | Start-of-frame strobe |
| frame_idx | input | FRM_W | Frame index that accompanies sof |
| pkt_valid | input | 1 | One completed data packet event |
| pkt_pid | input | 2 | Data PID code of the packet |
| pkt_bytes | input | PKT_W | Byte count of the packet |
| pkt_crc_bad | input | 1 | Packet failed its CRC check |
| retire | output | 1 | One-cycle descriptor retire pulse |
| txn_err | output | 1 | Transaction error (fulfillment or CRC) |
| buf_err | output | 1 | Buffer error (oversize or over budget) |
| bytes_left | output | BYTE_W | Remaining descriptor byte budget |
| next_req | output | 1 | Request to advance to the next descriptor |
| stray_pkt | output | 1 | One-cycle pulse for an ignored packet event |

## Verification
Every output of this block is a register. The result of a prime, a start-of-frame or a packet event sampled at one rising edge therefore appears right after that edge, with no further latency, and the retire and stray pulses are gone one edge later. The bench drives each stimulus on the falling edge, lets one rising edge pass, and compares all six outputs one time unit later. It then clears the strobes, so every comparison falls inside the single cycle in which a pulse is due. Held outputs such as the error flags, the request and the byte budget are compared again in each later step, and this shows that they persist.

// File: rtl/iso_retire_pkg.sv
package iso_retire_pkg;

    typedef enum logic [1:0] {
        PID_DATA0 = 2'd0,
        PID_DATA1 = 2'd1,
        PID_DATA2 = 2'd2,
        PID_MDATA = 2'd3
    } pid_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LIVE  = 2'd2
    } ep_state_e;

    typedef struct packed {
        logic txn_err;
        logic buf_err;
        logic nxt_req;
    } flags_t;

    function automatic logic [1:0] pick_mult(input logic [1:0] ovr, input logic [1:0] ep);
        if (ovr != 2'd0)
            return ovr;
        else if (ep != 2'd0)
            return ep;
        else
            return 2'd1;
    endfunction

endpackage

// File: rtl/iso_mult_counter.sv
module iso_mult_counter
    import iso_retire_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [1:0] load_val,
    input  logic       step,
    output logic [1:0] cnt,
    output logic [1:0] seen
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= 2'd0;
            seen <= 2'd0;
        end else if (load) begin
            cnt  <= load_val;
            seen <= 2'd0;
        end else if (step) begin
            cnt  <= cnt - 2'd1;
            seen <= seen + 2'd1;
        end
    end

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        step |-> (cnt != 2'd0));

endmodule

// File: rtl/iso_byte_budget.sv
module iso_byte_budget #(
    parameter int BYTE_W = 16,
    parameter int PKT_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              consume,
    input  logic [PKT_W-1:0]  pkt_bytes,
    input  logic [PKT_W-1:0]  max_pkt,
    output logic [BYTE_W-1:0] left,
    output logic              over_max,
    output logic              over_budget
);

    logic [BYTE_W-1:0] bytes_ext;

    assign bytes_ext   = BYTE_W'(pkt_bytes);
    assign over_max    = pkt_bytes > max_pkt;
    assign over_budget = bytes_ext > left;

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (load)
            left <= load_val;
        else if (consume)
            left <= over_budget ? '0 : left - bytes_ext;
    end

    assert_budget_shrinks_R10: assert property (@(posedge clk) disable iff (rst)
        !load |=> (left <= $past(left)));

endmodule

// File: rtl/iso_retire_ctrl.sv
module iso_retire_ctrl
    import iso_retire_pkg::*;
#(
    parameter int BYTE_W = 16,
    parameter int PKT_W  = 11,
    parameter int FRM_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        dtd_mult_ovr,
    input  logic [BYTE_W-1:0] dtd_byte_total,
    input  logic [1:0]        ep_mult,
    input  logic [PKT_W-1:0]  ep_max_pkt,
    input  logic              ep_is_tx,
    input  logic              prime,
    input  logic              sof,
    input  logic [FRM_W-1:0]  frame_idx,
    input  logic              pkt_valid,
    input  logic [1:0]        pkt_pid,
    input  logic [PKT_W-1:0]  pkt_bytes,
    input  logic              pkt_crc_bad,
    output logic              retire,
    output logic              txn_err,
    output logic              buf_err,
    output logic [BYTE_W-1:0] bytes_left,
    output logic              next_req,
    output logic              stray_pkt
);

    ep_state_e        state;
    flags_t           flags;
    logic [FRM_W-1:0] last_frm;
    logic [FRM_W-1:0] target_frm;
    logic [1:0]       cnt;
    logic [1:0]       seen;
    logic             over_max;
    logic             over_budget;
    logic             pkt_take;
    logic             open_hit;
    logic             reload;
    logic             finishing;
    logic             is_rx;

    assign is_rx     = !ep_is_tx;
    assign pkt_take  = pkt_valid && (state == ST_LIVE) && !sof && !prime;
    assign open_hit  = sof && !prime && (state == ST_ARMED) && (frame_idx == target_frm);
    assign reload    = open_hit || (sof && !prime && (state == ST_LIVE) && (seen == 2'd0));
    assign finishing = (cnt == 2'd1) || (is_rx && (pid_e'(pkt_pid) != PID_MDATA));

    iso_mult_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (reload),
        .load_val (pick_mult(dtd_mult_ovr, ep_mult)),
        .step     (pkt_take),
        .cnt      (cnt),
        .seen     (seen)
    );

    iso_byte_budget #(.BYTE_W(BYTE_W), .PKT_W(PKT_W)) u_budget (
        .clk         (clk),
        .rst         (rst),
        .load        (prime),
        .load_val    (dtd_byte_total),
        .consume     (pkt_take),
        .pkt_bytes   (pkt_bytes),
        .max_pkt     (ep_max_pkt),
        .left        (bytes_left),
        .over_max    (over_max),
        .over_budget (over_budget)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            flags      <= '0;
            last_frm   <= '0;
            target_frm <= '0;
            retire     <= 1'b0;
            stray_pkt  <= 1'b0;
        end else begin
            retire    <= 1'b0;
            stray_pkt <= pkt_valid && !pkt_take;
            if (sof)
                last_frm <= frame_idx;
            if (prime) begin
                state      <= ST_ARMED;
                target_frm <= last_frm + FRM_W'(1);
                flags      <= '0;
            end else if (sof) begin
                if (open_hit) begin
                    state <= ST_LIVE;
                end else if ((state == ST_LIVE) && (seen != 2'd0)) begin
                    flags.txn_err <= 1'b1;
                    flags.nxt_req <= 1'b1;
                    retire        <= 1'b1;
                    state         <= ST_IDLE;
                end
            end else if (pkt_take) begin
                if (is_rx && pkt_crc_bad)
                    flags.txn_err <= 1'b1;
                if (is_rx && (over_max || over_budget))
                    flags.buf_err <= 1'b1;
                if (finishing) begin
                    flags.nxt_req <= 1'b1;
                    retire        <= 1'b1;
                    state         <= ST_IDLE;
                end
            end
        end
    end

    assign txn_err  = flags.txn_err;
    assign buf_err  = flags.buf_err;
    assign next_req = flags.nxt_req;

    assert_retire_single_R4: assert property (@(posedge clk) disable iff (rst)
        retire |=> !retire);

    assert_retire_requests_R6: assert property (@(posedge clk) disable iff (rst)
        retire |-> next_req);

    assert_txn_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (txn_err && !prime) |=> txn_err);

    assert_buf_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (buf_err && !prime) |=> buf_err);

    assert_stray_no_effect_R12: assert property (@(posedge clk) disable iff (rst)
        (stray_pkt && !$past(prime)) |-> $stable(bytes_left));

endmodule

// File: tb/iso_retire_ctrl_bench.sv
module iso_retire_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  dtd_mult_ovr;
    logic [15:0] dtd_byte_total;
    logic [1:0]  ep_mult;
    logic [10:0] ep_max_pkt;
    logic        ep_is_tx;
    logic        prime, sof, pkt_valid, pkt_crc_bad;
    logic [10:0] frame_idx;
    logic [1:0]  pkt_pid;
    logic [10:0] pkt_bytes;
    logic        retire, txn_err, buf_err, next_req, stray_pkt;
    logic [15:0] bytes_left;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    // bench model of the requirements
    int          m_st;
    logic [1:0]  m_cnt, m_seen;
    logic [10:0] m_last, m_tgt;
    logic [15:0] m_left;
    logic        m_txn, m_buf, m_req, m_ret, m_stray;
    logic [10:0] fr;

    always #10 clk = ~clk;

    iso_retire_ctrl u_iso_retire_ctrl (
        .clk(clk), .rst(rst), .dtd_mult_ovr(dtd_mult_ovr), .dtd_byte_total(dtd_byte_total),
        .ep_mult(ep_mult), .ep_max_pkt(ep_max_pkt), .ep_is_tx(ep_is_tx), .prime(prime),
        .sof(sof), .frame_idx(frame_idx), .pkt_valid(pkt_valid), .pkt_pid(pkt_pid),
        .pkt_bytes(pkt_bytes), .pkt_crc_bad(pkt_crc_bad), .retire(retire), .txn_err(txn_err),
        .buf_err(buf_err), .bytes_left(bytes_left), .next_req(next_req), .stray_pkt(stray_pkt)
    );

    function automatic logic [1:0] exp_mult(input logic [1:0] o, input logic [1:0] e);
        return (o != 0) ? o : ((e != 0) ? e : 2'd1);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "retire", retire, m_ret);
        check(tag, "txn_err", txn_err, m_txn);
        check(tag, "buf_err", buf_err, m_buf);
        check(tag, "next_req", next_req, m_req);
        check(tag, "stray_pkt", stray_pkt, m_stray);
        check(tag, "bytes_left", bytes_left, m_left);
    endtask

    task automatic step(input string tag, input logic p, input logic s, input logic [10:0] fi,
                        input logic pv, input logic [1:0] pid, input logic [10:0] nb, input logic crc);
        logic take;
        @(negedge clk);
        prime = p; sof = s; frame_idx = fi; pkt_valid = pv;
        pkt_pid = pid; pkt_bytes = nb; pkt_crc_bad = crc;
        m_ret = 0;
        take = pv && (m_st == 2) && !s && !p;
        m_stray = pv && !take;
        if (p) begin
            m_st = 1; m_tgt = m_last + 11'd1;
            m_txn = 0; m_buf = 0; m_req = 0; m_left = dtd_byte_total;
        end else if (s) begin
            if (m_st == 1 && fi == m_tgt) begin
                m_st = 2; m_cnt = exp_mult(dtd_mult_ovr, ep_mult); m_seen = 0;
            end else if (m_st == 2) begin
                if (m_seen != 0) begin
                    m_txn = 1; m_req = 1; m_ret = 1; m_st = 0;
                end else begin
                    m_cnt = exp_mult(dtd_mult_ovr, ep_mult);
                end
            end
        end else if (take) begin
            m_cnt = m_cnt - 2'd1; m_seen = m_seen + 2'd1;
            if (!ep_is_tx) begin
                if (crc) m_txn = 1;
                if (nb > ep_max_pkt) m_buf = 1;
                if (16'(nb) > m_left) m_buf = 1;
            end
            m_left = (16'(nb) > m_left) ? 16'd0 : m_left - 16'(nb);
            if (m_cnt == 0 || (!ep_is_tx && pid != 2'd3)) begin
                m_ret = 1; m_req = 1; m_st = 0;
            end
        end
        if (s) m_last = fi;
        @(posedge clk);
        #1;
        compare_all(tag);
        prime = 0; sof = 0; pkt_valid = 0; pkt_crc_bad = 0;
    endtask

    task automatic do_prime(input string tag);
        step(tag, 1, 0, fr, 0, 0, 0, 0);
    endtask
    task automatic do_sof(input string tag);
        fr = fr + 11'd1;
        step(tag, 0, 1, fr, 0, 0, 0, 0);
    endtask
    task automatic do_pkt(input string tag, input logic [1:0] pid, input logic [10:0] nb, input logic crc);
        step(tag, 0, 0, fr, 1, pid, nb, crc);
    endtask
    task automatic setup(input logic [1:0] o, input logic [1:0] e, input logic [15:0] tot,
                         input logic [10:0] mp, input logic tx);
        dtd_mult_ovr = o; ep_mult = e; dtd_byte_total = tot; ep_max_pkt = mp; ep_is_tx = tx;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; prime = 0; sof = 0; pkt_valid = 0; pkt_crc_bad = 0;
        frame_idx = 0; pkt_pid = 0; pkt_bytes = 0; fr = 0;
        setup(0, 1, 100, 64, 1);
        m_st = 0; m_cnt = 0; m_seen = 0; m_last = 0; m_tgt = 0; m_left = 0;
        m_txn = 0; m_buf = 0; m_req = 0; m_ret = 0; m_stray = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        compare_all("R1 reset");

        // R12: packet while idle is dropped
        do_pkt("R12 idle packet", 2'd3, 11'd40, 0);

        // R2: wrong frame index keeps the endpoint waiting
        setup(0, 2, 1000, 512, 0);
        do_prime("R2 prime");
        fr = fr + 11'd1;
        do_sof("R2 skipped frame");
        do_pkt("R2 R12 packet before open", 2'd3, 11'd10, 0);
        do_prime("R2 reprime");
        do_sof("R2 open");
        // R3: endpoint multiplier 2, receive MDATA packets
        do_pkt("R3 first MDATA", 2'd3, 11'd100, 0);
        do_pkt("R3 R4 second MDATA retires", 2'd3, 11'd100, 0);
        step("R4 pulse gone", 0, 0, fr, 0, 0, 0, 0);

        // R3: override wins
        setup(1, 3, 500, 256, 1);
        do_prime("R3 prime ovr");
        do_sof("R3 open ovr");
        do_pkt("R3 R4 ovr one packet", 2'd0, 11'd200, 0);
        // R3: both zero -> 1
        setup(0, 0, 500, 256, 1);
        do_prime("R3 prime zero");
        do_sof("R3 open zero");
        do_pkt("R3 zero mult retires", 2'd0, 11'd20, 0);

        // R5: DATA0 on receive retires early
        setup(0, 3, 900, 256, 0);
        do_prime("R5 prime");
        do_sof("R5 open");
        do_pkt("R5 DATA0 retires", 2'd0, 11'd30, 0);

        // R6: partial frame
        setup(0, 3, 900, 256, 1);
        do_prime("R6 prime");
        do_sof("R6 open");
        do_pkt("R6 one of three", 2'd2, 11'd30, 0);
        do_sof("R6 fulfillment error");
        step("R11 flags held", 0, 0, fr, 0, 0, 0, 0);

        // R7: no activity
        do_prime("R7 R11 prime clears");
        do_sof("R7 open");
        for (int i = 0; i < 4; i++) do_sof("R7 idle frame");
        // R8: CRC error on receive keeps data
        ep_is_tx = 0;
        do_pkt("R8 crc packet", 2'd3, 11'd50, 1);
        // R9: oversize
        do_pkt("R9 oversize", 2'd3, 11'd300, 0);
        step("R11 errors held", 0, 0, fr, 0, 0, 0, 0);

        // R10: over budget
        setup(0, 3, 60, 512, 0);
        do_prime("R10 prime");
        do_sof("R10 open");
        do_pkt("R10 over budget", 2'd3, 11'd100, 0);
        do_pkt("R10 empty budget", 2'd3, 11'd0, 0);

        // R12: packet with sof is dropped
        setup(0, 2, 400, 256, 1);
        do_prime("R12 prime");
        do_sof("R12 open");
        fr = fr + 11'd1;
        step("R12 packet with sof", 0, 1, fr, 1, 2'd3, 11'd5, 0);

        // random descriptors
        for (int d = 0; d < 40; d++) begin
            setup(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                  16'($urandom_range(0, 1500)), 11'($urandom_range(1, 600)), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 5) == 0) do_pkt("R12 random stray", 2'd3, 11'd8, 0);
            do_prime("R2 random prime");
            do_sof("R3 random open");
            for (int f = 0; f < 3 && m_st == 2; f++) begin
                int k;
                k = $urandom_range(0, 3);
                for (int p = 0; p < k && m_st == 2; p++)
                    do_pkt("R4 R5 R8 R9 R10 random packet",
                           ($urandom_range(0, 4) == 0) ? 2'($urandom_range(0, 2)) : 2'd3,
                           11'($urandom_range(0, 700)), ($urandom_range(0, 7) == 0));
                if (m_st == 2) do_sof("R6 R7 random frame end");
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule